// File: doc/BRIEF.md
# Exclusive and Locked Response Handler

This block sits between a processor's load/store pipeline and a memory bus whose responses carry a two-bit code. The codes are normal success, exclusive success, slave error and decode error. The pipeline hands it one request at a time. A request is an exclusive read, an exclusive write, a locked swap or a plain write. The block issues the bus command or commands for it. From the final bus response it produces a completion pulse, together with a data-valid pulse, a store-exclusive status bit or an external-abort pulse.

A locked swap is a locked read followed by a locked write to the same address. If the locked read fails, the block must still release the bus lock. To do this it issues a dummy write to the same address with every byte strobe low and the lock signal dropped. Only when the response to that write has arrived does it report the abort. The block neither changes the processor's mode nor clears any exclusive reservation: an abort on an exclusive read leaves the reservation for software to clear.

Top module: `excl_rsp_handler`

## Requirements
- R1: After reset, `req_ready` is 1, `cmd_valid` is 0 and all completion outputs are 0. `cmd_valid` is never high while `req_ready` is high.
- R2: Request kind 2'b00 is an exclusive read. Its command has `cmd_write`=0, `cmd_excl`=1, `cmd_lock`=0, zero strobes and zero write data. A response of 2'b01 (exclusive success) gives `out_done` and `out_data_vld` with `out_rdata` equal to the response data, and no abort.
- R3: For an exclusive read, any response other than 2'b01, that is 2'b00 (normal success), 2'b10 (slave error) or 2'b11 (decode error), gives `out_done` and `out_abort` without `out_data_vld`.
- R4: Request kind 2'b01 is an exclusive write. Its command has `cmd_write`=1, `cmd_excl`=1, `cmd_lock`=0 and the request's data and strobes. A 2'b01 response gives `out_stat_vld` with `out_stat`=0 (store succeeded) and no abort.
- R5: For an exclusive write, a 2'b00 response gives `out_stat_vld` with `out_stat`=1 (store failed) and no abort.
- R6: For an exclusive write, a 2'b10 or 2'b11 response gives `out_abort` and no `out_stat_vld`.
- R7: Request kind 2'b10 is a locked swap. First comes a read with `cmd_lock`=1, `cmd_excl`=0, zero strobes and zero data. On a 2'b00 or 2'b01 response, a write follows to the same address with `cmd_lock`=1, `cmd_excl`=0 and the request's data and strobes. A non-error response to that write gives `out_data_vld` with `out_rdata` equal to the data of the locked read.
- R8: The locked write of a swap is decoded as a normal store: a 2'b10 or 2'b11 response gives `out_abort` and no `out_data_vld`.
- R9: When the swap's locked read gets 2'b10 or 2'b11, the next command is a release write to the same address with `cmd_write`=1, `cmd_strb`=0, `cmd_wdata`=0, `cmd_lock`=0 and `cmd_excl`=0.
- R10: No completion output pulses between the failed locked read and the response to the release write. That response, whatever its code, then gives `out_done` with `out_abort`.
- R11: Request kind 2'b11 is a plain write with `cmd_excl`=0 and `cmd_lock`=0. A 2'b10 or 2'b11 response gives `out_abort`. A success response gives `out_done` alone.
- R12: `out_done` lasts one cycle, the cycle after the final response is sampled. `out_data_vld`, `out_stat_vld` and `out_abort` are mutually exclusive and are high only together with `out_done`.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Request present |
| req_ready | output | 1 | Block idle, request accepted when valid |
| req_kind | input | 2 | 00 exclusive read, 01 exclusive write, 10 locked swap, 11 plain write |
| req_addr | input | ADDR_W | Request address |
| req_wdata | input | DATA_W | Store data |
| req_strb | input | DATA_W/8 | Store byte strobes |
| cmd_valid | output | 1 | Bus command valid |
| cmd_ready | input | 1 | Bus command accepted |
| cmd_write | output | 1 | Command is a write |
| cmd_addr | output | ADDR_W | Command address |
| cmd_wdata | output | DATA_W | Command write data |
| cmd_strb | output | DATA_W/8 | Command byte strobes |
| cmd_excl | output | 1 | Exclusive access marker |
| cmd_lock | output | 1 | Locked access marker |
| rsp_valid | input | 1 | Bus response valid |
| rsp_code | input | 2 | 00 okay, 01 exclusive okay, 10 slave error, 11 decode error |
| rsp_rdata | input | DATA_W | Response read data |
| out_done | output | 1 | Transaction complete pulse |
| out_data_vld | output | 1 | Read data valid pulse |
| out_rdata | output | DATA_W | Returned read data |
| out_stat_vld | output | 1 | Store-exclusive status valid pulse |
| out_stat | output | 1 | Status: 0 stored, 1 not stored |
| out_abort | output | 1 | External abort pulse |

## Verification
The bench drives all four response codes into every decode point. A design that accepted plain success on an exclusive read would return data where an abort is due. A design that treated plain success on an exclusive write as an error would abort instead of reporting status 1. Failing swap reads are answered with both a success and an error on the release write: a handler that reported the abort early, kept the lock up, left the strobes live or let the release response's code through would be caught by the command checks or by the completion scoreboard. The bench also stalls command acceptance and runs a swap whose locked write fails, to confirm that the data captured from the locked read survives the write phase only on success.

// File: rtl/excl_rsp_pkg.sv
// Package: shared encodings for the exclusive/locked response handler.
// Assumes a two-bit bus response code whose upper bit marks an error.
package excl_rsp_pkg;

    // Request kinds presented by the load/store pipeline.
    typedef enum logic [1:0] {
        K_EXCL_RD  = 2'b00,
        K_EXCL_WR  = 2'b01,
        K_SWAP     = 2'b10,
        K_PLAIN_WR = 2'b11
    } op_kind_t;

    // Bus response codes.
    typedef enum logic [1:0] {
        C_OKAY   = 2'b00,
        C_EXOKAY = 2'b01,
        C_SLVERR = 2'b10,
        C_DECERR = 2'b11
    } rsp_code_t;

    // Which bus command of a transaction is in flight.
    typedef enum logic [1:0] {
        PH_FIRST   = 2'b00,
        PH_SWAP_WR = 2'b01,
        PH_RELEASE = 2'b10
    } phase_t;

    // What the sequencer does after a response.
    typedef enum logic [1:0] {
        ACT_FINISH  = 2'b00,
        ACT_SWAP_WR = 2'b01,
        ACT_RELEASE = 2'b10
    } act_t;

    // Completion verdict produced by the decoder.
    typedef struct packed {
        logic data_ok;
        logic stat_vld;
        logic stat;
        logic abort;
    } verdict_t;

    // True for slave error and decode error.
    function automatic logic code_is_err(input rsp_code_t code);
        return code[1];
    endfunction

endpackage

// File: rtl/excl_rsp_decode.sv
// Module: excl_rsp_decode
// Purely combinational response table. From the request kind, the phase
// of the transaction and the bus response code it chooses the next action
// and the completion verdict. Assumes the caller only uses the outputs in
// a cycle where a response is actually being taken.
module excl_rsp_decode
    import excl_rsp_pkg::*;
(
    input  op_kind_t  kind,
    input  phase_t    phase,
    input  rsp_code_t code,
    output act_t      act,
    output verdict_t  verdict
);

    logic err;
    assign err = code_is_err(code);

    // Table lookup: one entry per (phase, kind) pair.
    always_comb begin
        act     = ACT_FINISH;
        verdict = '0;
        case (phase)
            PH_FIRST: begin
                case (kind)
                    K_EXCL_RD: begin
                        verdict.data_ok = (code == C_EXOKAY);
                        verdict.abort   = (code != C_EXOKAY);
                    end
                    K_EXCL_WR: begin
                        if (err) begin
                            verdict.abort = 1'b1;
                        end else begin
                            verdict.stat_vld = 1'b1;
                            verdict.stat     = (code == C_OKAY);
                        end
                    end
                    K_SWAP: begin
                        act = err ? ACT_RELEASE : ACT_SWAP_WR;
                    end
                    default: begin
                        verdict.abort = err;
                    end
                endcase
            end
            PH_SWAP_WR: begin
                verdict.data_ok = !err;
                verdict.abort   = err;
            end
            PH_RELEASE: begin
                verdict.abort = 1'b1;
            end
            default: begin
                verdict.abort = 1'b1;
            end
        endcase
    end

    // Guard: a verdict never carries two kinds of result at once (R12).
    always_comb begin
        if (act == ACT_FINISH) begin
            a_single_verdict_r12: assert ($countones({verdict.data_ok, verdict.stat_vld, verdict.abort}) <= 1)
                else $error("decoder produced more than one verdict");
        end
    end

endmodule

// File: rtl/excl_rsp_cmd_mux.sv
// Module: excl_rsp_cmd_mux
// Builds the bus command fields from the captured request and the current
// phase. Reads carry zero data and strobes; the release write carries zero
// data, zero strobes and no lock. Assumes the captured request is stable
// for the whole transaction.
module excl_rsp_cmd_mux
    import excl_rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  op_kind_t            kind,
    input  phase_t              phase,
    input  logic [ADDR_W-1:0]   addr,
    input  logic [DATA_W-1:0]   wdata,
    input  logic [STRB_W-1:0]   strb,
    output logic                cmd_write,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0]   cmd_wdata,
    output logic [STRB_W-1:0]   cmd_strb,
    output logic                cmd_excl,
    output logic                cmd_lock
);

    logic carries_data;

    // Direction and attribute selection per phase.
    always_comb begin
        cmd_addr  = addr;
        cmd_write = 1'b0;
        cmd_excl  = 1'b0;
        cmd_lock  = 1'b0;
        carries_data = 1'b0;
        case (phase)
            PH_FIRST: begin
                cmd_write    = (kind == K_EXCL_WR) || (kind == K_PLAIN_WR);
                cmd_excl     = (kind == K_EXCL_RD) || (kind == K_EXCL_WR);
                cmd_lock     = (kind == K_SWAP);
                carries_data = cmd_write;
            end
            PH_SWAP_WR: begin
                cmd_write    = 1'b1;
                cmd_lock     = 1'b1;
                carries_data = 1'b1;
            end
            PH_RELEASE: begin
                cmd_write = 1'b1;
            end
            default: begin
                cmd_write = 1'b0;
            end
        endcase
    end

    // Data and strobes only travel on stores that may modify memory.
    always_comb begin
        cmd_wdata = carries_data ? wdata : '0;
        cmd_strb  = carries_data ? strb  : '0;
    end

endmodule

// File: rtl/excl_rsp_seq.sv
// Module: excl_rsp_seq
// Transaction sequencer. Accepts one request when idle, presents one bus
// command at a time, takes the response and either finishes (registering
// the single-cycle completion outputs) or moves on to the swap's locked
// write or the lock-release write. Assumes a response only arrives after
// its command has been accepted.
module excl_rsp_seq
    import excl_rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    input  logic [1:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [STRB_W-1:0]   req_strb,
    output logic                req_ready,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    input  logic                rsp_valid,
    input  logic [DATA_W-1:0]   rsp_rdata,
    input  act_t                dec_act,
    input  verdict_t            dec_verdict,
    output logic                rsp_wait,
    output op_kind_t            cur_kind,
    output phase_t              cur_phase,
    output logic [ADDR_W-1:0]   cur_addr,
    output logic [DATA_W-1:0]   cur_wdata,
    output logic [STRB_W-1:0]   cur_strb,
    output logic                out_done,
    output logic                out_data_vld,
    output logic [DATA_W-1:0]   out_rdata,
    output logic                out_stat_vld,
    output logic                out_stat,
    output logic                out_abort
);

    typedef enum logic [1:0] {
        S_IDLE = 2'b00,
        S_CMD  = 2'b01,
        S_RSP  = 2'b10
    } seq_state_t;

    seq_state_t         state;
    logic [DATA_W-1:0]  swap_data;

    // Handshake views of the state.
    assign req_ready = (state == S_IDLE);
    assign cmd_valid = (state == S_CMD);
    assign rsp_wait  = (state == S_RSP);

    // State, request capture and completion register update.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state        <= S_IDLE;
            cur_kind     <= K_EXCL_RD;
            cur_phase    <= PH_FIRST;
            cur_addr     <= '0;
            cur_wdata    <= '0;
            cur_strb     <= '0;
            swap_data    <= '0;
            out_done     <= 1'b0;
            out_data_vld <= 1'b0;
            out_rdata    <= '0;
            out_stat_vld <= 1'b0;
            out_stat     <= 1'b0;
            out_abort    <= 1'b0;
        end else begin
            out_done     <= 1'b0;
            out_data_vld <= 1'b0;
            out_stat_vld <= 1'b0;
            out_stat     <= 1'b0;
            out_abort    <= 1'b0;
            case (state)
                S_IDLE: begin
                    if (req_valid) begin
                        cur_kind  <= op_kind_t'(req_kind);
                        cur_phase <= PH_FIRST;
                        cur_addr  <= req_addr;
                        cur_wdata <= req_wdata;
                        cur_strb  <= req_strb;
                        state     <= S_CMD;
                    end
                end
                S_CMD: begin
                    if (cmd_ready) begin
                        state <= S_RSP;
                    end
                end
                S_RSP: begin
                    if (rsp_valid) begin
                        case (dec_act)
                            ACT_SWAP_WR: begin
                                swap_data <= rsp_rdata;
                                cur_phase <= PH_SWAP_WR;
                                state     <= S_CMD;
                            end
                            ACT_RELEASE: begin
                                cur_phase <= PH_RELEASE;
                                state     <= S_CMD;
                            end
                            default: begin
                                out_done     <= 1'b1;
                                out_data_vld <= dec_verdict.data_ok;
                                out_stat_vld <= dec_verdict.stat_vld;
                                out_stat     <= dec_verdict.stat;
                                out_abort    <= dec_verdict.abort;
                                if (dec_verdict.data_ok) begin
                                    out_rdata <= (cur_phase == PH_SWAP_WR) ? swap_data : rsp_rdata;
                                end
                                state <= S_IDLE;
                            end
                        endcase
                    end
                end
                default: begin
                    state <= S_IDLE;
                end
            endcase
        end
    end

    // A presented command holds its address until accepted (R7).
    p_cmd_hold_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && !cmd_ready) |=> (cmd_valid && $stable(cur_addr) && $stable(cur_phase)))
        else $error("command changed before acceptance");

    // Completion pulses never repeat in consecutive cycles (R12).
    p_done_pulse_r12: assert property (@(posedge clk) disable iff (!rst_n)
        out_done |=> !out_done)
        else $error("completion held longer than one cycle");

    // A swap always passes through its first phase before any second phase (R9).
    p_phase_order_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (req_ready && req_valid) |=> (cmd_valid && cur_phase == PH_FIRST))
        else $error("transaction did not start in first phase");

endmodule

// File: rtl/excl_rsp_handler.sv
// Module: excl_rsp_handler (top)
// Turns bus responses of exclusive reads, exclusive writes, locked swaps
// and plain writes into completion pulses, store-exclusive status and
// external abort, and sequences the lock-release write after a failed
// locked read. Assumes one outstanding transaction at a time; the
// exclusive reservation itself is kept elsewhere.
module excl_rsp_handler
    import excl_rsp_pkg::*;
#(
    parameter int ADDR_W = 32,
    parameter int DATA_W = 32,
    localparam int STRB_W = DATA_W / 8
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                req_valid,
    output logic                req_ready,
    input  logic [1:0]          req_kind,
    input  logic [ADDR_W-1:0]   req_addr,
    input  logic [DATA_W-1:0]   req_wdata,
    input  logic [STRB_W-1:0]   req_strb,
    output logic                cmd_valid,
    input  logic                cmd_ready,
    output logic                cmd_write,
    output logic [ADDR_W-1:0]   cmd_addr,
    output logic [DATA_W-1:0]   cmd_wdata,
    output logic [STRB_W-1:0]   cmd_strb,
    output logic                cmd_excl,
    output logic                cmd_lock,
    input  logic                rsp_valid,
    input  logic [1:0]          rsp_code,
    input  logic [DATA_W-1:0]   rsp_rdata,
    output logic                out_done,
    output logic                out_data_vld,
    output logic [DATA_W-1:0]   out_rdata,
    output logic                out_stat_vld,
    output logic                out_stat,
    output logic                out_abort
);

    op_kind_t           cur_kind;
    phase_t             cur_phase;
    logic [ADDR_W-1:0]  cur_addr;
    logic [DATA_W-1:0]  cur_wdata;
    logic [STRB_W-1:0]  cur_strb;
    act_t               dec_act;
    verdict_t           dec_verdict;
    logic               rsp_wait;
    logic               rsp_take;
    rsp_code_t          code_t;

    assign code_t   = rsp_code_t'(rsp_code);
    assign rsp_take = rsp_wait && rsp_valid;

    excl_rsp_decode u_decode (
        .kind    (cur_kind),
        .phase   (cur_phase),
        .code    (code_t),
        .act     (dec_act),
        .verdict (dec_verdict)
    );

    excl_rsp_cmd_mux #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_cmd_mux (
        .kind      (cur_kind),
        .phase     (cur_phase),
        .addr      (cur_addr),
        .wdata     (cur_wdata),
        .strb      (cur_strb),
        .cmd_write (cmd_write),
        .cmd_addr  (cmd_addr),
        .cmd_wdata (cmd_wdata),
        .cmd_strb  (cmd_strb),
        .cmd_excl  (cmd_excl),
        .cmd_lock  (cmd_lock)
    );

    excl_rsp_seq #(.ADDR_W(ADDR_W), .DATA_W(DATA_W)) u_seq (
        .clk          (clk),
        .rst_n        (rst_n),
        .req_valid    (req_valid),
        .req_kind     (req_kind),
        .req_addr     (req_addr),
        .req_wdata    (req_wdata),
        .req_strb     (req_strb),
        .req_ready    (req_ready),
        .cmd_valid    (cmd_valid),
        .cmd_ready    (cmd_ready),
        .rsp_valid    (rsp_valid),
        .rsp_rdata    (rsp_rdata),
        .dec_act      (dec_act),
        .dec_verdict  (dec_verdict),
        .rsp_wait     (rsp_wait),
        .cur_kind     (cur_kind),
        .cur_phase    (cur_phase),
        .cur_addr     (cur_addr),
        .cur_wdata    (cur_wdata),
        .cur_strb     (cur_strb),
        .out_done     (out_done),
        .out_data_vld (out_data_vld),
        .out_rdata    (out_rdata),
        .out_stat_vld (out_stat_vld),
        .out_stat     (out_stat),
        .out_abort    (out_abort)
    );

    // Idle handler presents no command (R1).
    p_idle_quiet_r1: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> !cmd_valid)
        else $error("command while idle");

    // Exclusive read success returns the bus data (R2).
    p_xrd_data_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_EXCL_RD && rsp_code == 2'b01)
        |=> (out_data_vld && !out_abort && out_rdata == $past(rsp_rdata)))
        else $error("exclusive read success not delivered");

    // Exclusive read without exclusive success aborts (R3).
    p_xrd_abort_r3: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_EXCL_RD && rsp_code != 2'b01)
        |=> (out_abort && !out_data_vld))
        else $error("exclusive read failure not aborted");

    // Exclusive write exclusive-okay reports status 0 (R4).
    p_xwr_pass_r4: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_EXCL_WR && rsp_code == 2'b01)
        |=> (out_stat_vld && !out_stat && !out_abort))
        else $error("exclusive write success status wrong");

    // Exclusive write plain okay reports status 1 (R5).
    p_xwr_fail_status_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_EXCL_WR && rsp_code == 2'b00)
        |=> (out_stat_vld && out_stat && !out_abort))
        else $error("exclusive write okay status wrong");

    // Exclusive write error aborts (R6).
    p_xwr_err_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_EXCL_WR && rsp_code[1])
        |=> (out_abort && !out_stat_vld))
        else $error("exclusive write error not aborted");

    // Successful locked read leads to the locked write (R7).
    p_swap_write_r7: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_SWAP && !rsp_code[1])
        |=> (cmd_valid && cmd_write && cmd_lock && !cmd_excl && !out_done))
        else $error("locked write did not follow");

    // Failed locked read leads to a zero-strobe unlocked release write (R9).
    p_release_cmd_r9: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_FIRST && cur_kind == K_SWAP && rsp_code[1])
        |=> (cmd_valid && cmd_write && cmd_strb == '0 && !cmd_lock
             && cmd_addr == $past(cmd_addr) && !out_done))
        else $error("release write malformed");

    // Release response always ends in abort (R10).
    p_release_abort_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (rsp_take && cur_phase == PH_RELEASE) |=> (out_done && out_abort))
        else $error("release did not abort");

    // Plain write never marks exclusive or locked (R11).
    p_plain_attr_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (cmd_valid && cur_kind == K_PLAIN_WR) |-> (!cmd_excl && !cmd_lock))
        else $error("plain write carries attributes");

    // Result pulses only with completion, at most one kind (R12).
    p_verdict_with_done_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (out_data_vld || out_stat_vld || out_abort)
        |-> (out_done && $countones({out_data_vld, out_stat_vld, out_abort}) == 1))
        else $error("result pulse outside completion");

endmodule

// File: tb/test_excl_rsp_handler.sv
// Scoreboard bench: the driver pushes the expected completion into a
// queue and plays the bus; a monitor pops and compares on each completion.
module test_excl_rsp_handler;

    localparam int AW = 32;
    localparam int DW = 32;
    localparam int SW = DW / 8;

    logic           clk = 1'b0;
    logic           rst_n = 1'b0;
    logic           req_valid = 1'b0;
    logic           req_ready;
    logic [1:0]     req_kind = 2'b00;
    logic [AW-1:0]  req_addr = '0;
    logic [DW-1:0]  req_wdata = '0;
    logic [SW-1:0]  req_strb = '0;
    logic           cmd_valid;
    logic           cmd_ready = 1'b0;
    logic           cmd_write;
    logic [AW-1:0]  cmd_addr;
    logic [DW-1:0]  cmd_wdata;
    logic [SW-1:0]  cmd_strb;
    logic           cmd_excl;
    logic           cmd_lock;
    logic           rsp_valid = 1'b0;
    logic [1:0]     rsp_code = 2'b00;
    logic [DW-1:0]  rsp_rdata = '0;
    logic           out_done;
    logic           out_data_vld;
    logic [DW-1:0]  out_rdata;
    logic           out_stat_vld;
    logic           out_stat;
    logic           out_abort;

    int n_checks = 0;
    int n_fail = 0;
    bit finished = 1'b0;
    bit prev_done = 1'b0;

    logic [35:0] exp_q[$];
    string       tag_q[$];

    always #10 clk = ~clk;

    excl_rsp_handler #(.ADDR_W(AW), .DATA_W(DW)) i_excl_rsp_handler (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_kind(req_kind),
        .req_addr(req_addr), .req_wdata(req_wdata), .req_strb(req_strb),
        .cmd_valid(cmd_valid), .cmd_ready(cmd_ready), .cmd_write(cmd_write),
        .cmd_addr(cmd_addr), .cmd_wdata(cmd_wdata), .cmd_strb(cmd_strb),
        .cmd_excl(cmd_excl), .cmd_lock(cmd_lock),
        .rsp_valid(rsp_valid), .rsp_code(rsp_code), .rsp_rdata(rsp_rdata),
        .out_done(out_done), .out_data_vld(out_data_vld), .out_rdata(out_rdata),
        .out_stat_vld(out_stat_vld), .out_stat(out_stat), .out_abort(out_abort)
    );

    task automatic check(input bit ok, input string tag, input logic [127:0] got, input logic [127:0] exp);
        n_checks++;
        if (!ok) begin
            n_fail++;
            $display("FAIL %s: actual %h expected %h", tag, got, exp);
        end
    endtask

    task automatic summary();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    // Expected item: {data_vld, stat_vld, stat, abort, rdata}
    task automatic expect_done(input bit dv, input bit sv, input bit st, input bit ab,
                               input logic [DW-1:0] rd, input string tag);
        exp_q.push_back({dv, sv, st, ab, rd});
        tag_q.push_back(tag);
    endtask

    // Monitor: compares every completion against the scoreboard (R12 framing).
    always @(negedge clk) begin
        if (rst_n && !finished) begin
            if (prev_done && out_done)
                check(1'b0, "R12 completion longer than one cycle", 1, 0);
            if (!out_done && (out_data_vld || out_stat_vld || out_abort))
                check(1'b0, "R12 result without completion",
                      {out_data_vld, out_stat_vld, out_abort}, 0);
            if (out_done) begin
                if (exp_q.size() == 0) begin
                    check(1'b0, "R12 unexpected completion", 1, 0);
                end else begin
                    logic [35:0] e;
                    string t;
                    logic [35:0] g;
                    e = exp_q.pop_front();
                    t = tag_q.pop_front();
                    g = {out_data_vld, out_stat_vld, out_stat, out_abort,
                         (e[35] ? out_rdata : e[31:0])};
                    check(g == e, t, g, e);
                end
            end
            prev_done = out_done;
        end
    end

    // Bus model for one command: check fields, accept, respond.
    task automatic bus_phase(input bit w, input logic [AW-1:0] a, input logic [DW-1:0] wd,
                             input logic [SW-1:0] st, input bit ex, input bit lk,
                             input logic [1:0] code, input logic [DW-1:0] rd,
                             input int stall, input string tag);
        int waits = 0;
        while (!cmd_valid && waits < 20) begin
            @(negedge clk);
            waits++;
        end
        check(cmd_valid && cmd_write == w && cmd_addr == a && cmd_wdata == wd &&
              cmd_strb == st && cmd_excl == ex && cmd_lock == lk,
              {tag, " command"},
              {cmd_valid, cmd_write, cmd_excl, cmd_lock, cmd_strb, cmd_addr, cmd_wdata},
              {1'b1, w, ex, lk, st, a, wd});
        check(!out_done, {tag, " no early completion"}, out_done, 0);
        for (int i = 0; i < stall; i++) begin
            @(negedge clk);
            check(cmd_valid && cmd_addr == a, {tag, " R7 hold while stalled"},
                  {cmd_valid, cmd_addr}, {1'b1, a});
        end
        cmd_ready = 1'b1;
        @(negedge clk);
        cmd_ready = 1'b0;
        rsp_valid = 1'b1;
        rsp_code  = code;
        rsp_rdata = rd;
        @(negedge clk);
        rsp_valid = 1'b0;
        rsp_rdata = '0;
    endtask

    task automatic send_req(input logic [1:0] kind, input logic [AW-1:0] a,
                            input logic [DW-1:0] wd, input logic [SW-1:0] st);
        @(negedge clk);
        check(req_ready, "R1 ready before request", req_ready, 1);
        req_valid = 1'b1;
        req_kind  = kind;
        req_addr  = a;
        req_wdata = wd;
        req_strb  = st;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // Driver: exclusive read.
    task automatic do_xrd(input logic [AW-1:0] a, input logic [1:0] code,
                          input logic [DW-1:0] rd, input string tag);
        bit ok = (code == 2'b01);
        expect_done(ok, 1'b0, 1'b0, !ok, ok ? rd : '0, tag);
        send_req(2'b00, a, 32'hDEAD_BEEF, 4'hF);
        bus_phase(1'b0, a, '0, '0, 1'b1, 1'b0, code, rd, 0, tag);
    endtask

    // Driver: exclusive write.
    task automatic do_xwr(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [SW-1:0] st, input logic [1:0] code, input string tag);
        bit err = code[1];
        expect_done(1'b0, !err, (code == 2'b00), err, '0, tag);
        send_req(2'b01, a, wd, st);
        bus_phase(1'b1, a, wd, st, 1'b1, 1'b0, code, 32'h1234_5678, 1, tag);
    endtask

    // Driver: locked swap, with release write when the read fails.
    task automatic do_swap(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                           input logic [SW-1:0] st, input logic [1:0] code_rd,
                           input logic [DW-1:0] rd, input logic [1:0] code_wr,
                           input int stall, input string tag);
        if (code_rd[1]) begin
            expect_done(1'b0, 1'b0, 1'b0, 1'b1, '0, tag);
            send_req(2'b10, a, wd, st);
            bus_phase(1'b0, a, '0, '0, 1'b0, 1'b1, code_rd, rd, stall, {tag, " locked read"});
            bus_phase(1'b1, a, '0, '0, 1'b0, 1'b0, code_wr, 32'hFFFF_FFFF, stall,
                      {tag, " R9 release write"});
        end else begin
            expect_done(!code_wr[1], 1'b0, 1'b0, code_wr[1], code_wr[1] ? '0 : rd, tag);
            send_req(2'b10, a, wd, st);
            bus_phase(1'b0, a, '0, '0, 1'b0, 1'b1, code_rd, rd, stall, {tag, " locked read"});
            bus_phase(1'b1, a, wd, st, 1'b0, 1'b1, code_wr, 32'h0BAD_0BAD, stall,
                      {tag, " R7 locked write"});
        end
    endtask

    // Driver: plain write.
    task automatic do_pwr(input logic [AW-1:0] a, input logic [DW-1:0] wd,
                          input logic [SW-1:0] st, input logic [1:0] code, input string tag);
        expect_done(1'b0, 1'b0, 1'b0, code[1], '0, tag);
        send_req(2'b11, a, wd, st);
        bus_phase(1'b1, a, wd, st, 1'b0, 1'b0, code, 32'h0, 0, tag);
    endtask

    // Watchdog: a hung run counts as a failure.
    initial begin
        repeat (20000) @(posedge clk);
        check(1'b0, "watchdog expired", 1, 0);
        summary();
    end

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        // R1: reset state.
        check(req_ready && !cmd_valid && !out_done && !out_data_vld && !out_stat_vld &&
              !out_abort && !out_stat, "R1 reset state",
              {req_ready, cmd_valid, out_done, out_data_vld, out_stat_vld, out_stat, out_abort},
              7'b1000000);

        do_xrd(32'h0000_1000, 2'b01, 32'hA5A5_0001, "R2 exclusive read exokay");
        do_xrd(32'h0000_1004, 2'b00, 32'h1111_2222, "R3 exclusive read okay aborts");
        do_xrd(32'h0000_1008, 2'b10, 32'h3333_4444, "R3 exclusive read slverr aborts");
        do_xrd(32'h0000_100C, 2'b11, 32'h5555_6666, "R3 exclusive read decerr aborts");

        do_xwr(32'h0000_2000, 32'h0000_00FF, 4'b0001, 2'b01, "R4 exclusive write exokay status 0");
        do_xwr(32'h0000_2004, 32'hCAFE_F00D, 4'b1111, 2'b00, "R5 exclusive write okay status 1");
        do_xwr(32'h0000_2008, 32'h0102_0304, 4'b0110, 2'b10, "R6 exclusive write slverr aborts");
        do_xwr(32'h0000_200C, 32'h0506_0708, 4'b1100, 2'b11, "R6 exclusive write decerr aborts");

        do_swap(32'h0000_3000, 32'h0000_00FF, 4'b0001, 2'b00, 32'h0000_0000, 2'b00, 0,
                "R7 swap okay returns old data");
        do_swap(32'h0000_3004, 32'h7777_8888, 4'b1111, 2'b01, 32'h9999_AAAA, 2'b01, 2,
                "R7 swap with stalls returns old data");
        do_swap(32'h0000_3008, 32'h1357_9BDF, 4'b1111, 2'b01, 32'h2468_ACE0, 2'b10, 0,
                "R8 swap locked write error aborts");
        do_swap(32'h0000_300C, 32'hFEED_FACE, 4'b1111, 2'b10, 32'h0, 2'b00, 0,
                "R10 release after slverr aborts on okay");
        do_swap(32'h0000_3010, 32'hFEED_FACE, 4'b0011, 2'b11, 32'h0, 2'b10, 1,
                "R10 release after decerr aborts on slverr");

        do_pwr(32'h0000_4000, 32'h4242_4242, 4'b1111, 2'b00, "R11 plain write okay");
        do_pwr(32'h0000_4004, 32'h4343_4343, 4'b0101, 2'b11, "R11 plain write decerr aborts");
        do_xrd(32'h0000_1010, 2'b01, 32'h0F0F_F0F0, "R2 exclusive read after plain write");

        repeat (3) @(negedge clk);
        check(exp_q.size() == 0, "R12 every expected completion seen", exp_q.size(), 0);
        check(req_ready && !cmd_valid, "R1 idle at end", {req_ready, cmd_valid}, 2'b10);
        summary();
    end

endmodule